// File: doc/BRIEF.md
# Tick-Driven One-Shot / Periodic Down Timer

This block counts down once per tick strobe, a single-cycle pulse that marks each 1 µs period of a 1 MHz time base. Software programs it through two word registers. The first is a preset word. It holds an enable flag, an auto-reload flag and a count, and software writes the count as the interval minus one. The second is a status word. Reading it returns the remaining count and the pending-interrupt flag. Writing a one to its clear bit drops the interrupt.

When the count is zero on a tick, the timer expires. It then raises an active-high level interrupt. In one-shot mode it stops by clearing its own enable flag. In periodic mode it reloads the preset count and keeps running.

Several copies can share one address space. Each copy decodes only the two word offsets above its `BASE_ADDR` parameter. Register writes are plain single-cycle strobes with no back-pressure: a write is taken on the clock edge at which `reg_wr` is high. Read data is combinational from `reg_addr`.

Top module: `tick_down_timer`

## Requirements
- R1: After reset the interrupt output is low, and both registers read as zero.
- R2: A write to offset 0 loads the preset fields: bit 31 is enable, bit 30 is periodic and bits [28:0] are the count. The running count is set to the written count at the same edge. A read of offset 0 returns the current enable in bit 31, periodic in bit 30 and the preset count in [28:0].
- R3: While enabled, the count drops by exactly one on each cycle with `tick` high. On cycles without a tick the count holds.
- R4: With a preset count P, the interrupt rises on the (P+1)-th tick after the write. That is the tick seen while the count is zero. A preset of 0 expires on the first tick, and the full count 0x1fffffff loads and counts down.
- R5: On expiry in one-shot mode (bit 30 = 0), the enable bit reads 0 and the count stays at 0. Later ticks cause no further expiry.
- R6: On expiry in periodic mode, the count reloads to P and the timer stays enabled. The next expiry follows after another P+1 ticks.
- R7: Writing 0 to offset 0 stops the timer. Later ticks neither change the count nor raise the interrupt.
- R8: A preset write while the timer is running restarts the count from the new value. It leaves a pending interrupt set.
- R9: The interrupt is a level that stays high until a write to offset 4 with bit 30 set. A write to offset 4 with bit 30 clear has no effect. Bit 30 of an offset-4 read is the pending flag, and bits [28:0] are the remaining count.
- R10: If an expiry and a clear fall in the same cycle, the interrupt stays set.
- R11: Writes to addresses other than `BASE_ADDR` and `BASE_ADDR+4` are ignored, and reads of them return zero.
- R12: If a preset write and a tick fall in the same cycle, the written count is taken and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe per 1 µs time-base period |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq | output | 1 | Active-high level interrupt |

## Verification
The countdown is tried with several presets:
- Small one-shot presets (0 and 3) show whether expiry lands on tick P+1 rather than P or P+2.
- A periodic preset of 2, run over two full periods, separates a correct reload from a stop or a reload to the wrong value.
- Cycles with no tick between writes show that the count holds without a tick.
- The full 29-bit preset exposes truncation of the count field.

Same-cycle collisions are driven on purpose: write with tick, and expiry with clear. These fix the priority order. Writes outside the instance's window, and clear writes without bit 30, show that those accesses have no effect.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int REG_W     = 32;
  localparam int EN_BIT    = 31;
  localparam int PER_BIT   = 30;
  localparam int CLR_BIT   = 30;
  localparam int OFS_PRE   = 0;
  localparam int OFS_STA   = 4;
  localparam int MAX_CNT_W = 29;

  typedef struct packed {
    logic en;
    logic per;
  } mode_t;
endpackage

// File: rtl/timer_regif.sv
module timer_regif
  import timer_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 0,
  parameter int CNT_W     = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  mode_t             cur_mode,
  input  logic [CNT_W-1:0]  preset_cnt,
  input  logic [CNT_W-1:0]  count,
  input  logic              irq,
  output logic              load,
  output mode_t             load_mode,
  output logic [CNT_W-1:0]  load_cnt,
  output logic              irq_clr,
  output logic [REG_W-1:0]  reg_rdata
);
  localparam logic [ADDR_W-1:0] A_PRE = ADDR_W'(BASE_ADDR + OFS_PRE);
  localparam logic [ADDR_W-1:0] A_STA = ADDR_W'(BASE_ADDR + OFS_STA);

  logic sel_pre, sel_sta;

  assign sel_pre       = (reg_addr == A_PRE);
  assign sel_sta       = (reg_addr == A_STA);
  assign load          = reg_wr && sel_pre;
  assign load_mode.en  = reg_wdata[EN_BIT];
  assign load_mode.per = reg_wdata[PER_BIT];
  assign load_cnt      = reg_wdata[CNT_W-1:0];
  assign irq_clr       = reg_wr && sel_sta && reg_wdata[CLR_BIT];

  always_comb begin
    reg_rdata = '0;
    if (sel_pre) begin
      reg_rdata[EN_BIT]      = cur_mode.en;
      reg_rdata[PER_BIT]     = cur_mode.per;
      reg_rdata[CNT_W-1:0]   = preset_cnt;
    end else if (sel_sta) begin
      reg_rdata[CLR_BIT]     = irq;
      reg_rdata[CNT_W-1:0]   = count;
    end
  end

  // R11: a write outside the window must not produce a load or a clear
  p_decode_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr != A_PRE && reg_addr != A_STA) |-> (!load && !irq_clr));
endmodule

// File: rtl/timer_core.sv
module timer_core
  import timer_pkg::*;
#(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  mode_t            load_mode,
  input  logic [CNT_W-1:0] load_cnt,
  output mode_t            mode,
  output logic [CNT_W-1:0] preset_cnt,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic step, at_zero;

  assign at_zero = (count == '0);
  assign step    = mode.en && tick && !load;
  assign expire  = step && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= '0;
      preset_cnt <= '0;
      count      <= '0;
    end else if (load) begin
      mode       <= load_mode;
      preset_cnt <= load_cnt;
      count      <= load_cnt;
    end else if (step) begin
      if (!at_zero) begin
        count <= count - ONE;
      end else if (mode.per) begin
        count <= preset_cnt;
      end else begin
        mode.en <= 1'b0;
      end
    end
  end

  p_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_cnt)));
  p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode.en && tick && !load && count != '0) |=> (count == $past(count) - ONE));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count));
  p_oneshot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !mode.per) |=> (!mode.en && count == '0));
  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && mode.per) |=> (mode.en && count == $past(preset_cnt)));
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode.en && !load) |=> ($stable(count) && !mode.en));
endmodule

// File: rtl/timer_irq.sv
module timer_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq <= 1'b0;
    else if (expire) irq <= 1'b1;
    else if (clr)    irq <= 1'b0;
  end

  p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> irq);
  p_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr) |=> irq);
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && clr) |=> irq);
  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !expire) |=> !irq);
endmodule

// File: rtl/tick_down_timer.sv
module tick_down_timer
  import timer_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 0,
  parameter int CNT_W     = MAX_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  logic             load, irq_clr, expire;
  mode_t            load_mode, mode;
  logic [CNT_W-1:0] load_cnt, preset_cnt, count;

  timer_regif #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .CNT_W(CNT_W)) u_regif (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cur_mode(mode), .preset_cnt(preset_cnt),
    .count(count), .irq(irq), .load(load), .load_mode(load_mode),
    .load_cnt(load_cnt), .irq_clr(irq_clr), .reg_rdata(reg_rdata)
  );

  timer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
    .load_mode(load_mode), .load_cnt(load_cnt), .mode(mode),
    .preset_cnt(preset_cnt), .count(count), .expire(expire)
  );

  timer_irq u_irq (
    .clk(clk), .rst_n(rst_n), .expire(expire), .clr(irq_clr), .irq(irq)
  );

  // R2: a preset write is visible on the preset port at the next edge
  p_preset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (preset_cnt == $past(reg_wdata[CNT_W-1:0])));
endmodule

// File: tb/test_tick_down_timer.sv
module test_tick_down_timer;
  localparam int BASE = 'h20;
  localparam logic [7:0] A_PRE = 8'h20;
  localparam logic [7:0] A_STA = 8'h24;
  localparam logic [31:0] EN  = 32'h8000_0000;
  localparam logic [31:0] PER = 32'h4000_0000;
  localparam logic [31:0] CLR = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2.5 clk = ~clk;

  tick_down_timer #(.ADDR_W(8), .BASE_ADDR(BASE), .CNT_W(29)) i_tick_down_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd(A_PRE, d); check("R1 preset", d, 32'd0);
    rd(A_STA, d); check("R1 status", d, 32'd0);
  endtask

  task automatic t_oneshot();
    logic [31:0] d;
    wr(A_PRE, EN | 32'd3);
    rd(A_PRE, d); check("R2 preset readback", d, EN | 32'd3);
    rd(A_STA, d); check("R2 status count", d, 32'd3);
    ticks(1); rd(A_STA, d); check("R3 dec", d, 32'd2);
    repeat (4) @(negedge clk);
    rd(A_STA, d); check("R3 hold no tick", d, 32'd2);
    ticks(2); check("R4 no early irq", {31'd0, irq}, 32'd0);
    ticks(1); check("R4 irq on tick P+1", {31'd0, irq}, 32'd1);
    rd(A_PRE, d); check("R5 enable cleared", d, 32'd3);
    wr(A_STA, CLR);
    ticks(3);
    rd(A_STA, d); check("R5 no re-expiry", d, 32'd0);
  endtask

  task automatic t_periodic();
    logic [31:0] d;
    wr(A_PRE, EN | PER | 32'd2);
    ticks(3); check("R6 first expiry", {31'd0, irq}, 32'd1);
    rd(A_STA, d); check("R6 reload", d, CLR | 32'd2);
    wr(A_STA, CLR);
    ticks(2); check("R6 no early 2nd", {31'd0, irq}, 32'd0);
    ticks(1); check("R6 second expiry", {31'd0, irq}, 32'd1);
    rd(A_PRE, d); check("R6 still enabled", d, EN | PER | 32'd2);
    wr(A_STA, CLR);
  endtask

  task automatic t_stop();
    logic [31:0] d;
    wr(A_PRE, EN | 32'd4);
    ticks(2); rd(A_STA, d); check("R7 running", d, 32'd2);
    wr(A_PRE, 32'd0);
    ticks(6);
    rd(A_STA, d); check("R7 stopped status", d, 32'd0);
    rd(A_PRE, d); check("R7 stopped preset", d, 32'd0);
  endtask

  task automatic t_restart_clear();
    logic [31:0] d;
    wr(A_PRE, EN | 32'd0);
    ticks(1); check("R4 preset 0 first tick", {31'd0, irq}, 32'd1);
    wr(A_PRE, EN | 32'd10);
    ticks(3); rd(A_STA, d); check("R8 counting", d, CLR | 32'd7);
    wr(A_PRE, EN | 32'd5);
    rd(A_STA, d); check("R8 restart keeps irq", d, CLR | 32'd5);
    wr(A_STA, 32'h0000_0001);
    check("R9 bit30 clear ignored", {31'd0, irq}, 32'd1);
    rd(A_STA, d); check("R9 pending flag", d[31:29], 3'b010);
    wr(A_STA, CLR);
    check("R9 clear", {31'd0, irq}, 32'd0);
    wr(A_PRE, 32'd0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    wr(A_PRE, EN | 32'd0);
    ticks(1);
    wr(A_PRE, EN | 32'd0);
    @(negedge clk); tick = 1'b1; reg_wr = 1'b1; reg_addr = A_STA; reg_wdata = CLR;
    @(negedge clk); tick = 1'b0; reg_wr = 1'b0;
    check("R10 expiry beats clear", {31'd0, irq}, 32'd1);
    wr(A_STA, CLR);
    wr(A_PRE, EN | 32'd8);
    @(negedge clk); tick = 1'b1; reg_wr = 1'b1; reg_addr = A_PRE; reg_wdata = EN | 32'd5;
    @(negedge clk); tick = 1'b0; reg_wr = 1'b0;
    rd(A_STA, d); check("R12 write beats tick", d, 32'd5);
    wr(A_PRE, 32'd0);
  endtask

  task automatic t_decode();
    logic [31:0] d;
    wr(8'h00, EN | 32'd1);
    wr(8'h04, EN | 32'd1);
    ticks(3);
    check("R11 no irq from foreign write", {31'd0, irq}, 32'd0);
    rd(A_PRE, d); check("R11 preset untouched", d, 32'd0);
    rd(8'h28, d); check("R11 foreign read zero", d, 32'd0);
    wr(A_PRE, EN | 32'd0);
    ticks(1);
    wr(8'h44, CLR);
    check("R11 foreign clear ignored", {31'd0, irq}, 32'd1);
    wr(A_STA, CLR);
  endtask

  task automatic t_max();
    logic [31:0] d;
    wr(A_PRE, EN | 32'h1fff_ffff);
    rd(A_STA, d); check("R4 max load", d, 32'h1fff_ffff);
    ticks(1); rd(A_STA, d); check("R3 max dec", d, 32'h1fff_fffe);
    wr(A_PRE, 32'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_oneshot();
    t_periodic();
    t_stop();
    t_restart_clear();
    t_collide();
    t_decode();
    t_max();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule